// File: doc/BRIEF.md
# Bit-stuffing NRZI line encoder and decoder

The block serialises a stream of data bits onto one line using inverted non-return-to-zero coding. A zero bit flips the line level and a one bit keeps it. One bit leaves per bit-time enable, and data bits are taken through a valid/ready handshake. A long run of ones would give the line no edges, so the encoder counts consecutive transmitted ones. Once the count reaches the limit, the next bit time carries an extra zero, and the input is held off for that one bit time.

A matching decoder sits in the same module with its own sample strobe and line input. It compares each sampled level with the one before it. It removes the symbol that follows a full run of ones, and it reports an error when that symbol shows no edge. The encoder gives a symbol strobe, so the line and the strobe can be looped straight back into the decoder for self-checking.

Top module: `nrzi_stuff_codec`

## Requirements
- R1: After reset, line_out is 1, in_ready is 1, tx_sym is 0, rx_valid is 0 and rx_stuff_err is 0.
- R2: A data bit of 0 accepted on a cycle with bit_en, in_valid and in_ready all high makes line_out invert on the next cycle, with tx_sym high in that cycle.
- R3: A data bit of 1 accepted the same way leaves line_out unchanged, with tx_sym high in the next cycle.
- R4: On a cycle without bit_en, no bit is accepted, line_out keeps its level and tx_sym is 0 on the next cycle.
- R5: After RUN_LIMIT (default 6) consecutive transmitted ones, in_ready is low until the next bit_en cycle. That cycle sends a stuffed 0 (line inverts, tx_sym high) and raises in_ready again. Every transmitted 0, stuffed or data, clears the ones count.
- R6: line_out never stays at one level for more than RUN_LIMIT consecutive transmitted symbols.
- R7: On an rx_en cycle, the decoded bit is 1 when rx_line equals the previously sampled level and 0 otherwise. The previous level starts at 1 after reset. rx_valid and rx_bit appear on the following cycle.
- R8: The decoder discards the symbol that follows RUN_LIMIT decoded ones, so rx_valid stays low for it. If that symbol decodes as 1, rx_stuff_err pulses for one cycle. The ones count is cleared either way.
- R9: With line_out and tx_sym looped into rx_line and rx_en, the decoded bits match the accepted data bits in order, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-time enable for the transmitter |
| in_valid | input | 1 | Data bit offered |
| in_bit | input | 1 | Data bit value |
| in_ready | output | 1 | Transmitter can accept a bit (low while a stuffed bit is due) |
| line_out | output | 1 | Encoded line level |
| tx_sym | output | 1 | A symbol was launched on line_out this cycle |
| rx_en | input | 1 | Decoder sample strobe |
| rx_line | input | 1 | Line level into the decoder |
| rx_valid | output | 1 | Decoded data bit present |
| rx_bit | output | 1 | Decoded data bit |
| rx_stuff_err | output | 1 | Stuffed position carried no transition |

## Verification
Two transmitter functions can claim the same bit time: a stuffed zero that is due and a fresh data bit offered at the same enable. The bench keeps in_valid high with the next bit waiting while in_ready drops. It requires that the enable first sends the edge of the stuffing and the waiting bit goes out only on the following enable. This is judged by the stall count for each pattern and by the decoded word after loop-back. On the receive side, the dropped stuffed position and the stuffing error fall on the same decode slot. Hand-driven line levels show that the slot never yields data and that it raises the error only when the level does not change.

// File: rtl/nrzi_stuff_codec.sv
module nrzi_stuff_codec #(
  parameter int RUN_LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic line_out,
  output logic tx_sym,
  input  logic rx_en,
  input  logic rx_line,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_stuff_err
);
  localparam int CW = $clog2(RUN_LIMIT + 1);

  logic [CW-1:0] tx_run, rx_run;
  logic line_q, stuff_due, take, send0;
  logic rx_prev, rx_same, rx_drop;

  assign stuff_due = (tx_run == CW'(RUN_LIMIT));
  assign in_ready  = !stuff_due;
  assign take      = bit_en && in_valid && !stuff_due;
  assign send0     = bit_en && (stuff_due || (in_valid && !in_bit));
  assign line_out  = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      tx_run <= '0;
      tx_sym <= 1'b0;
    end else begin
      tx_sym <= take || (bit_en && stuff_due);
      if (send0) begin
        line_q <= !line_q;
        tx_run <= '0;
      end else if (take) begin
        tx_run <= tx_run + 1'b1;
      end
    end
  end

  assign rx_same = (rx_line == rx_prev);
  assign rx_drop = (rx_run == CW'(RUN_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_prev      <= 1'b1;
      rx_run       <= '0;
      rx_valid     <= 1'b0;
      rx_bit       <= 1'b0;
      rx_stuff_err <= 1'b0;
    end else begin
      rx_valid     <= rx_en && !rx_drop;
      rx_stuff_err <= rx_en && rx_drop && rx_same;
      if (rx_en) begin
        rx_prev <= rx_line;
        rx_bit  <= rx_same;
        if (rx_drop || !rx_same) rx_run <= '0;
        else                     rx_run <= rx_run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrzi_stuff_codec_chk.sv
module nrzi_stuff_codec_chk #(
  parameter int RUN_LIMIT = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_bit,
  input logic in_ready,
  input logic line_out,
  input logic tx_sym,
  input logic rx_valid,
  input logic rx_stuff_err
);
  logic last_lvl;
  int   flat_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_lvl <= 1'b1;
      flat_run <= 0;
    end else if (tx_sym) begin
      last_lvl <= line_out;
      flat_run <= (line_out == last_lvl) ? flat_run + 1 : 0;
    end
  end

  // R2
  zero_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && in_valid && in_ready && !in_bit |=> line_out != $past(line_out) && tx_sym);
  // R3
  one_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && in_valid && in_ready && in_bit |=> $stable(line_out) && tx_sym);
  // R4
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_out) && !tx_sym);
  // R5
  stall_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !bit_en |=> !in_ready);
  // R5
  stuff_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && bit_en |=> in_ready && tx_sym && line_out != $past(line_out));
  // R6
  edge_density_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flat_run <= RUN_LIMIT);
  // R8
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_valid);
endmodule

bind nrzi_stuff_codec nrzi_stuff_codec_chk #(.RUN_LIMIT(RUN_LIMIT)) chk_i (.*);

// File: tb/nrzi_stuff_codec_tb_top.sv
module nrzi_stuff_codec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, line_out, tx_sym;
  logic loop_sel = 1'b1, man_en = 1'b0, man_line = 1'b1;
  logic rx_en, rx_line, rx_valid, rx_bit, rx_stuff_err;

  always #(CLK_PERIOD/2) clk = !clk;

  assign rx_en   = loop_sel ? tx_sym   : man_en;
  assign rx_line = loop_sel ? line_out : man_line;

  nrzi_stuff_codec dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .line_out(line_out), .tx_sym(tx_sym),
    .rx_en(rx_en), .rx_line(rx_line), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_stuff_err(rx_stuff_err)
  );

  int checks = 0, errors = 0, stalls = 0;
  int rx_cnt = 0, err_seen = 0, flat = 0, max_flat = 0;
  logic [15:0] rx_word = '0;
  logic lvl = 1'b1;
  bit done = 0;

  // data word (sent LSB first), expected stuffed bits
  localparam logic [20:0] VEC [7] = '{
    {16'h0000, 5'd0}, {16'hFFFF, 5'd2}, {16'h003F, 5'd1}, {16'h001F, 5'd0},
    {16'hFC0F, 5'd1}, {16'hAAAA, 5'd0}, {16'hFEFF, 5'd2}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (rx_cnt < 16) rx_word[rx_cnt] = rx_bit;
        rx_cnt++;
      end
      if (rx_stuff_err) err_seen++;
      if (tx_sym) begin
        flat = (line_out == lvl) ? flat + 1 : 0;
        lvl = line_out;
        if (flat > max_flat) max_flat = flat;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    man_en = 1'b0; man_line = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stalls = 0; rx_cnt = 0; err_seen = 0; flat = 0; max_flat = 0; lvl = 1'b1; rx_word = '0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_bit = b;
    while (!in_ready) begin
      bit_en = 1'b1; in_valid = 1'b1; stalls++;
      @(negedge clk);
    end
    bit_en = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; in_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    if (!in_ready) begin
      bit_en = 1'b1; stalls++;
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic man_sym(input logic l);
    @(negedge clk);
    man_en = 1'b1; man_line = l;
    @(negedge clk);
    man_en = 1'b0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(line_out == 1'b1, "R1 line idle", line_out, 1);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(!tx_sym && !rx_valid && !rx_stuff_err, "R1 strobes", tx_sym, 0);

    in_valid = 1'b1; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_out == 1'b1, "R4 no enable line", line_out, 1);
    chk(tx_sym == 1'b0, "R4 no enable sym", tx_sym, 0);
    in_valid = 1'b0;

    send_bit(1'b0);
    chk(line_out == 1'b0, "R2 zero toggles", line_out, 0);
    bit_en = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; in_valid = 1'b0;
    chk(line_out == 1'b0 && tx_sym, "R3 one holds", line_out, 0);

    do_reset();
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R5 stall after run", in_ready, 0);
    in_valid = 1'b1; in_bit = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && line_out == 1'b1, "R5 stall held", in_ready, 0);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; in_valid = 1'b0;
    chk(line_out == 1'b0 && tx_sym, "R5 stuffed edge", line_out, 0);
    chk(in_ready == 1'b1, "R5 ready back", in_ready, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 run cleared by stuff", in_ready, 1);

    do_reset();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    @(negedge clk);
    chk(in_ready == 1'b1 && stalls == 0, "R5 run cleared by data zero", stalls, 0);

    for (int v = 0; v < 7; v++) begin
      do_reset();
      loop_sel = 1'b1;
      for (int i = 0; i < 16; i++) send_bit(VEC[v][5+i]);
      flush();
      repeat (4) @(negedge clk);
      chk(rx_cnt == 16, "R9 bit count", rx_cnt, 16);
      chk(rx_word == VEC[v][20:5], "R9 loop-back word", rx_word, VEC[v][20:5]);
      chk(stalls == int'(VEC[v][4:0]), "R5 stuff count", stalls, VEC[v][4:0]);
      chk(max_flat <= 6, "R6 edge density", max_flat, 6);
      chk(err_seen == 0, "R8 no error", err_seen, 0);
    end

    do_reset();
    loop_sel = 1'b0;
    man_sym(1'b0);
    chk(rx_valid && rx_bit == 1'b0, "R7 change decodes 0", rx_bit, 0);
    man_sym(1'b0);
    chk(rx_valid && rx_bit == 1'b1, "R7 same decodes 1", rx_bit, 1);

    do_reset();
    for (int i = 0; i < 6; i++) man_sym(1'b1);
    man_sym(1'b1);
    chk(!rx_valid, "R8 dropped on error", rx_valid, 0);
    chk(rx_stuff_err, "R8 error flagged", rx_stuff_err, 1);

    do_reset();
    for (int i = 0; i < 6; i++) man_sym(1'b1);
    man_sym(1'b0);
    chk(!rx_valid && !rx_stuff_err, "R8 stuffed zero dropped", rx_valid, 0);
    man_sym(1'b0);
    chk(rx_valid && rx_bit == 1'b1, "R8 next bit kept", rx_bit, 1);
    loop_sel = 1'b1;

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule